// File: doc/BRIEF.md
# Software-Acknowledged Priority Interrupt Controller

This block arbitrates among a small set of internal interrupt sources using fixed priority, where source 0 has the highest priority. Each source has an under-service flag. While a source's flag is set, that source and every source of lower priority are held off. The processor cannot read these flags. It learns about them only through their effect on the request line and on the vector.

A configuration bit selects software acknowledge. With that bit set, a processor read of the vector takes the place of a hardware acknowledge cycle: it marks the highest-priority eligible source as under service. The vector can be read in two forms. The raw form returns the stored byte unchanged. The modified form replaces the low bits with a code for the source. Both forms have the same effect on the under-service flags.

A separate status read shows every pending source, so a handler can find other requests. A reset-under-service pulse at the end of a handler releases the highest-priority active flag. The enable-in input qualifies the request and is normally tied high.

Top module: `swack_int_ctrl`

## Requirements
- R1: The pending register takes `srcReq` at every clock. A read of address 2 returns the pending bits in `rdData[NUM_SRC-1:0]` and zeros above them.
- R2: `intReq` is high exactly when some source i meets all of these conditions at once. Its pending bit is set. Its enable bit is set; the enable mask is written at address 2, bit i. Master enable is set; this is config bit 0, written at address 1. `iei` is high. No under-service flag is set at any index from 0 to i. `intReq` follows `iei` in the same cycle.
- R3: Software-acknowledge mode is config bit 1. In this mode, a read of address 0 or address 1 sets the under-service flag of exactly one source: the lowest-index source that is eligible in the R2 sense.
- R4: A vector read made while no source is eligible sets no under-service flag.
- R5: A read of the raw vector (address 0) and a read of the modified vector (address 1) change the under-service flags in the same way.
- R6: An active under-service flag at index k masks requests from index k and from every higher index. Requests from lower indices still raise `intReq`.
- R7: A one-cycle `resetIus` pulse clears only the lowest-index active under-service flag.
- R8: Dropping a source's pending condition does not clear its under-service flag.
- R9: The modified vector is `{stored[7:3], code}`. The code is the index of the highest-priority eligible source, or 3'b111 when no source is eligible. The stored byte is written at address 0. In software-acknowledge mode the status always appears, whatever config bit 2 (no-vector) and config bit 3 (vector-includes-status) hold. Outside that mode the status appears only when bit 3 is set and bit 2 is clear. Otherwise the stored byte is returned unchanged.
- R10: Outside software-acknowledge mode, vector reads leave the under-service flags unchanged.
- R11: After reset, `rdData` is 0, `intReq` is 0, and all registers and flags are clear. `rdData` updates one cycle after `rdEn`; a read of address 3 returns the enable mask. At all other times `rdData` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 vector, 1 config, 2 enable mask |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 2 | Read address: 0 raw vector, 1 modified vector, 2 pending, 3 mask |
| rdData | output | 8 | Registered read data |
| srcReq | input | NUM_SRC | Source pending conditions, level sensitive |
| iei | input | 1 | Enable-in qualifier for the request |
| resetIus | input | 1 | Reset-under-service command pulse |
| intReq | output | 1 | Interrupt request |

## Verification
A source request reaches the pending register one edge after it is driven. From there it feeds `intReq` through logic only, so `intReq` is due one cycle after `srcReq` changes. A change on `iei` reaches `intReq` in the same cycle. Read data, flag updates from a vector read, and flag clears from `resetIus` all take effect at the first edge after the strobe. The bench drives stimulus after the falling edge and updates its model at the rising edge, using the same inputs the design sees. It compares both outputs at the next falling edge, so every result is checked in the cycle it is due.

// File: rtl/swack_pkg.sv
package swack_pkg;
  typedef enum logic [1:0] {
    ADDR_RAWVEC = 2'd0,
    ADDR_MODVEC = 2'd1,
    ADDR_PEND   = 2'd2,
    ADDR_MASK   = 2'd3
  } rdAddr_e;

  localparam logic [1:0] WADDR_VEC  = 2'd0;
  localparam logic [1:0] WADDR_CFG  = 2'd1;
  localparam logic [1:0] WADDR_MASK = 2'd2;

  localparam int CFG_W     = 4;
  localparam int CFG_MIE   = 0;
  localparam int CFG_SOFT  = 1;
  localparam int CFG_NOVEC = 2;
  localparam int CFG_VIS   = 3;

  typedef struct packed {
    logic    wrVector;
    logic    wrConfig;
    logic    wrMask;
    logic    loadRd;
    logic    ackRead;
    logic    clrIus;
    rdAddr_e rdSel;
  } strobes_t;
endpackage

// File: rtl/swack_ctrl.sv
module swack_ctrl
  import swack_pkg::*;
(
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       rdEn,
  input  logic [1:0] rdAddr,
  input  logic       softAck,
  input  logic       resetIus,
  output strobes_t   strb
);
  logic vecRead;

  always_comb begin
    vecRead       = (rdAddr == ADDR_RAWVEC) || (rdAddr == ADDR_MODVEC);
    strb          = '0;
    strb.wrVector = wrEn && (wrAddr == WADDR_VEC);
    strb.wrConfig = wrEn && (wrAddr == WADDR_CFG);
    strb.wrMask   = wrEn && (wrAddr == WADDR_MASK);
    strb.loadRd   = rdEn;
    strb.rdSel    = rdAddr_e'(rdAddr);
    // Either vector form acts as the acknowledge, but only in software mode.
    strb.ackRead  = rdEn && softAck && vecRead;
    strb.clrIus   = resetIus;
  end
endmodule

// File: rtl/swack_datapath.sv
module swack_datapath
  import swack_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               iei,
  output logic [DATA_W-1:0]  rdData,
  output logic               intReq,
  output logic               softAck
);
  localparam int CODE_W = $clog2(NUM_SRC + 1);
  localparam logic [CODE_W-1:0] NONE_CODE = {CODE_W{1'b1}};

  logic [DATA_W-1:0]  vecReg;
  logic [CFG_W-1:0]   cfgReg;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] ipReg;
  logic [NUM_SRC-1:0] iusReg;

  logic [NUM_SRC-1:0] blocked;
  logic [NUM_SRC-1:0] eligible;
  logic [NUM_SRC-1:0] hitOneHot;
  logic [NUM_SRC-1:0] clrOneHot;
  logic [CODE_W-1:0]  hitCode;
  logic               statusOn;
  logic [DATA_W-1:0]  modVec;
  logic [DATA_W-1:0]  rdMux;

  assign softAck = cfgReg[CFG_SOFT];

  // A flag at index k blocks index k and every index above it.
  always_comb begin
    logic run;
    run = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      run        = run | iusReg[i];
      blocked[i] = run;
    end
  end

  assign eligible = ipReg & maskReg & ~blocked & {NUM_SRC{cfgReg[CFG_MIE] & iei}};
  assign intReq   = |eligible;

  // Lowest eligible index wins.
  always_comb begin
    hitCode   = NONE_CODE;
    hitOneHot = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        hitCode   = CODE_W'(i);
        hitOneHot = NUM_SRC'(1) << i;
      end
    end
  end

  // Lowest active flag is the one a reset command releases.
  always_comb begin
    clrOneHot = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (iusReg[i]) clrOneHot = NUM_SRC'(1) << i;
    end
  end

  assign statusOn = cfgReg[CFG_SOFT] | (cfgReg[CFG_VIS] & ~cfgReg[CFG_NOVEC]);
  assign modVec   = statusOn ? {vecReg[DATA_W-1:CODE_W], hitCode} : vecReg;

  always_comb begin
    unique case (strb.rdSel)
      ADDR_RAWVEC: rdMux = vecReg;
      ADDR_MODVEC: rdMux = modVec;
      ADDR_PEND:   rdMux = DATA_W'(ipReg);
      default:     rdMux = DATA_W'(maskReg);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecReg  <= '0;
      cfgReg  <= '0;
      maskReg <= '0;
      ipReg   <= '0;
      iusReg  <= '0;
      rdData  <= '0;
    end else begin
      ipReg <= srcReq;
      if (strb.wrVector) vecReg  <= wrData;
      if (strb.wrConfig) cfgReg  <= wrData[CFG_W-1:0];
      if (strb.wrMask)   maskReg <= wrData[NUM_SRC-1:0];
      if (strb.loadRd)   rdData  <= rdMux;
      iusReg <= (iusReg & ~(strb.clrIus ? clrOneHot : '0))
              | (strb.ackRead ? hitOneHot : '0);
    end
  end

  AST_SET_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ackRead |=> ((iusReg & ~$past(iusReg)) == '0)); // R10
  AST_ONE_SET_PER_READ: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackRead |=> $onehot0(iusReg & ~$past(iusReg))); // R3
  AST_IDLE_READ_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRead && !intReq && !strb.clrIus) |=> (iusReg == $past(iusReg))); // R4
  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrIus |=> ((~iusReg & $past(iusReg)) == '0)); // R8
  AST_CLEAR_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrIus |=> ($countones($past(iusReg) & ~iusReg) <= 1)); // R7
  AST_REQ_NEEDS_IEI: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> iei); // R2
endmodule

// File: rtl/swack_int_ctrl.sv
module swack_int_ctrl
  import swack_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               rdEn,
  input  logic [1:0]         rdAddr,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               iei,
  input  logic               resetIus,
  output logic               intReq
);
  strobes_t strb;
  logic     softAck;

  swack_ctrl uCtrl (
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .softAck  (softAck),
    .resetIus (resetIus),
    .strb     (strb)
  );

  swack_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .srcReq  (srcReq),
    .iei     (iei),
    .rdData  (rdData),
    .intReq  (intReq),
    .softAck (softAck)
  );

  AST_RDDATA_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R11
endmodule

// File: tb/swack_int_ctrl_test.sv
module swack_int_ctrl_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = '0;
  logic [7:0]   wrData = '0;
  logic         rdEn = 1'b0;
  logic [1:0]   rdAddr = '0;
  logic [7:0]   rdData;
  logic [N-1:0] srcReq = '0;
  logic         iei = 1'b1;
  logic         resetIus = 1'b0;
  logic         intReq;

  int    testsRun = 0;
  int    testsFailed = 0;
  string curTag = "R11";

  // Reference model state
  logic [7:0]   mVec, mRd;
  logic [3:0]   mCfg;
  logic [N-1:0] mMask, mIp, mIus;

  always #4 clk = ~clk;

  swack_int_ctrl uut (.*);

  function automatic logic [N-1:0] mElig();
    logic [N-1:0] e = '0;
    for (int i = 0; i < N; i++) begin
      bit held = 0;
      for (int j = 0; j <= i; j++) if (mIus[j]) held = 1;
      if (mIp[i] && mMask[i] && mCfg[0] && iei && !held) e[i] = 1'b1;
    end
    return e;
  endfunction

  function automatic int firstSet(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    int  top, low;
    bit  stat;
    if (!rstN) begin
      mVec = '0; mRd = '0; mCfg = '0; mMask = '0; mIp = '0; mIus = '0;
      return;
    end
    top  = firstSet(mElig());
    stat = mCfg[1] || (mCfg[3] && !mCfg[2]);
    if (rdEn) begin
      case (rdAddr)
        2'd0: mRd = mVec;
        2'd1: mRd = stat ? {mVec[7:3], (top < 0) ? 3'd7 : 3'(top)} : mVec;
        2'd2: mRd = 8'(mIp);
        default: mRd = 8'(mMask);
      endcase
    end
    if (resetIus) begin
      low = firstSet(mIus);
      if (low >= 0) mIus[low] = 1'b0;
    end
    if (rdEn && mCfg[1] && rdAddr <= 2'd1 && top >= 0) mIus[top] = 1'b1;
    if (wrEn && wrAddr == 2'd0) mVec = wrData;
    if (wrEn && wrAddr == 2'd1) mCfg = wrData[3:0];
    if (wrEn && wrAddr == 2'd2) mMask = wrData[N-1:0];
    mIp = srcReq;
  endtask

  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    chk(rdData == mRd, {curTag, " rdData"}, rdData, mRd);
    chk(intReq == (|mElig()), {curTag, " intReq"}, intReq, |mElig());
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    wrEn = 1; wrAddr = a; wrData = d; step(); wrEn = 0;
  endtask
  task automatic rd(logic [1:0] a);
    rdEn = 1; rdAddr = a; step(); rdEn = 0;
  endtask
  task automatic rstIus();
    resetIus = 1; step(); resetIus = 0;
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    @(negedge clk);
    curTag = "R11"; step(); step();
    chk(rdData == 8'h00, "R11 reset rdData", rdData, 0);
    chk(intReq == 1'b0, "R11 reset intReq", intReq, 0);
    rstN = 1;
    wr(2'd0, 8'hA8); wr(2'd2, 8'h3F); wr(2'd1, 8'h01);
    curTag = "R2"; srcReq = 6'b000100; step();
    chk(intReq == 1, "R2 pending raises intReq", intReq, 1);
    curTag = "R1"; rd(2'd2);
    chk(rdData == 8'h04, "R1 pending read", rdData, 8'h04);
    curTag = "R9"; rd(2'd1);
    chk(rdData == 8'hA8, "R9 no status outside mode", rdData, 8'hA8);
    wr(2'd1, 8'h09); rd(2'd1);
    chk(rdData == 8'hAA, "R9 status with bit3", rdData, 8'hAA);
    curTag = "R10"; rd(2'd0);
    chk(intReq == 1, "R10 no flag set outside mode", intReq, 1);
    curTag = "R3"; wr(2'd1, 8'h03); rd(2'd1);
    chk(rdData == 8'hAA && intReq == 0, "R3 ack masks source", {rdData, 7'b0, intReq}, 16'hAA00);
    curTag = "R6"; srcReq = 6'b010100; step();
    chk(intReq == 0, "R6 lower priority masked", intReq, 0);
    srcReq = 6'b010101; step();
    chk(intReq == 1, "R6 higher priority passes", intReq, 1);
    curTag = "R5"; rd(2'd0);
    chk(rdData == 8'hA8 && intReq == 0, "R5 raw read acks", {rdData, 7'b0, intReq}, 16'hA800);
    curTag = "R8"; srcReq = 6'b000000; step(); step(); rstIus();
    srcReq = 6'b010000; step();
    chk(intReq == 0, "R8 flag survives source drop", intReq, 0);
    curTag = "R7"; rstIus();
    chk(intReq == 1, "R7 one reset clears one flag", intReq, 1);
    rd(2'd1);
    chk(rdData == 8'hAC, "R9 code for source 4", rdData, 8'hAC);
    rstIus();
    curTag = "R4"; srcReq = '0; step(); rd(2'd1);
    chk(rdData == 8'hAF, "R9 none code", rdData, 8'hAF);
    srcReq = 6'b100000; step();
    chk(intReq == 1, "R4 idle read set no flag", intReq, 1);
    curTag = "R9"; wr(2'd1, 8'h07); rd(2'd1);
    chk(rdData == 8'hAD, "R9 bits ignored in mode", rdData, 8'hAD);
    rstIus();
    curTag = "R2"; iei = 0; step();
    chk(intReq == 0, "R2 iei low blocks", intReq, 0);
    rd(2'd0); iei = 1; step();
    chk(intReq == 1, "R2 no ack while iei low", intReq, 1);
    curTag = "R11"; rd(2'd3);
    chk(rdData == 8'h3F, "R11 mask readback", rdData, 8'h3F);
    curTag = "R3";
    for (int k = 0; k < 400; k++) begin
      srcReq   = N'($urandom);
      iei      = ($urandom % 8) != 0;
      resetIus = ($urandom % 5) == 0;
      rdEn     = ($urandom % 3) == 0;
      rdAddr   = 2'($urandom);
      wrEn     = ($urandom % 12) == 0;
      wrAddr   = 2'($urandom % 3);
      wrData   = (wrAddr == 2'd1) ? 8'($urandom | 1) : 8'($urandom);
      step();
    end
    wrEn = 0; rdEn = 0; resetIus = 0;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule